// File: doc/BRIEF.md
# Aligned Pulse Width Modulator

This block turns a stream of 6-bit width codes into one output pulse per pixel period for a print engine. A fast clock drives a free-running tick counter. The counter divides every period into 64 equal ticks. On the clock edge that closes a period, the block samples the width code and two placement controls. Those values pass through a two-deep holding pipeline, so each code shapes the period that follows the period in which it was sampled.

The placement controls choose where the high time sits in the period. It can start on tick 0, finish on tick 63, or sit in the middle. A force-high input bypasses the modulator completely and drives the output high at once, with no clock edge needed. An active-low asynchronous reset clears the counter and both pipeline stages.

Top module: `aligned_pwm`

## Requirements
- R1: Inputs held steady through period k are sampled on the edge that ends period k and shape period k+2. Period 0 is the 64 ticks that begin when reset is released.
- R2: Code 0x3F gives a high output on all 64 ticks, for every setting of the placement controls.
- R3: Code 0x00 gives a low output on all 64 ticks, for every setting of the placement controls.
- R4: A nonzero code c gives exactly c+1 high ticks in its period. So 0x0F gives 16 ticks, 0x1F gives 32 and 0x2F gives 48.
- R5: When single_edge_i=1 and late_edge_i=1, the high ticks are the last ones in the period, ending at tick 63.
- R6: When single_edge_i=1 and late_edge_i=0, the high ticks begin at tick 0.
- R7: When single_edge_i=0, the pulse is centred. It starts at tick floor((64-w)/2), where w is the width, so an odd spare tick falls at the end of the period. late_edge_i has no effect in this mode.
- R8: While force_hi_i=1, pwm_o is 1 at once, without waiting for a clock edge, and it stays 1 across clock edges.
- R9: While rst_ni=0, pwm_o is 0 at once. After release, the first two periods are fully low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, 64 ticks per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 6 | Width code for a coming period |
| single_edge_i | input | 1 | 1: single-edge placement, 0: centred |
| late_edge_i | input | 1 | In single-edge mode, 1 places the pulse at the period end |
| force_hi_i | input | 1 | Asynchronous force of the output to high |
| pwm_o | output | 1 | Modulated output |

## Verification
The assertions assume that the code and the placement controls settle before the edge that closes a period. They also assume that reset is asserted from time zero. The bench changes the stimulus one time unit after the first tick edge of a period and holds it for the whole period, so the sampling edge never sees a value in transition. Force and reset are switched between clock edges, away from any edge, so that their asynchronous effect can be seen without a clock racing them.

// File: rtl/aligned_pwm_pkg.sv
package aligned_pwm_pkg;

  typedef enum logic [1:0] {
    ALIGN_CENTRE = 2'b00,
    ALIGN_LEFT   = 2'b01,
    ALIGN_RIGHT  = 2'b10
  } align_e;

  function automatic align_e decode_align(input logic single_edge, input logic late_edge);
    if (!single_edge) return ALIGN_CENTRE;
    return late_edge ? ALIGN_RIGHT : ALIGN_LEFT;
  endfunction

endpackage

// File: rtl/pwm_tick_cnt.sv
module pwm_tick_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] tick_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] TICK_MAX = '1;

  logic [CNT_W-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + 1'b1;
  end

  assign tick_o = tick_q;
  assign last_o = (tick_q == TICK_MAX);
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture
  import aligned_pwm_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  align_e            align_i,
  output logic [CODE_W-1:0] code_o,
  output align_e            align_o
);
  typedef struct packed {
    logic [CODE_W-1:0] code;
    align_e            align;
  } slot_t;

  slot_t in_s;
  slot_t stage_q [DEPTH];

  assign in_s = '{code: code_i, align: align_i};

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stage_q[g] <= '0;
        else if (load_i) stage_q[g] <= in_s;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stage_q[g] <= '0;
        else if (load_i) stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign code_o  = stage_q[DEPTH-1].code;
  assign align_o = stage_q[DEPTH-1].align;
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
  import aligned_pwm_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  input  align_e            align_i,
  input  logic [CODE_W-1:0] tick_i,
  output logic              pulse_o
);
  localparam int             W_W    = CODE_W + 1;
  localparam logic [W_W-1:0] TICKS  = W_W'(1 << CODE_W);

  logic [W_W-1:0] width, spare, start, stop, tick_ext;

  always_comb begin
    width    = (code_i == '0) ? '0 : ({1'b0, code_i} + 1'b1);
    spare    = TICKS - width;
    tick_ext = {1'b0, tick_i};
    unique case (align_i)
      ALIGN_LEFT:  start = '0;
      ALIGN_RIGHT: start = spare;
      default:     start = spare >> 1;  // odd spare tick lands at the end
    endcase
    stop    = start + width;
    pulse_o = (tick_ext >= start) && (tick_ext < stop);
  end
endmodule

// File: rtl/aligned_pwm.sv
module aligned_pwm
  import aligned_pwm_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              single_edge_i,
  input  logic              late_edge_i,
  input  logic              force_hi_i,
  output logic              pwm_o
);
  logic [CODE_W-1:0] tick_q;
  logic              period_end;
  logic [CODE_W-1:0] act_code;
  align_e            act_align;
  align_e            in_align;
  logic              pulse;

  assign in_align = decode_align(single_edge_i, late_edge_i);

  pwm_tick_cnt #(.CNT_W(CODE_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_q),
    .last_o (period_end)
  );

  pwm_capture #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (period_end),
    .code_i  (code_i),
    .align_i (in_align),
    .code_o  (act_code),
    .align_o (act_align)
  );

  pwm_shaper #(.CODE_W(CODE_W)) u_shaper (
    .code_i  (act_code),
    .align_i (act_align),
    .tick_i  (tick_q),
    .pulse_o (pulse)
  );

  // force path is combinational; reset gates the pulse through cleared registers
  assign pwm_o = force_hi_i | (rst_ni & pulse);
endmodule

// File: rtl/aligned_pwm_chk.sv
module aligned_pwm_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              force_hi_i,
  input logic              pwm_o,
  input logic [CODE_W-1:0] tick_i,
  input logic [CODE_W-1:0] act_code_i,
  input logic [1:0]        act_align_i
);
  localparam logic [CODE_W-1:0] ALL_ONES = '1;

  p_force_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_hi_i |-> pwm_o);

  p_zero_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_code_i == '0 && !force_hi_i) |-> !pwm_o);

  p_full_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_code_i == ALL_ONES) |-> pwm_o);

  p_hold_in_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i != '0) |-> ($stable(act_code_i) && $stable(act_align_i)));

  p_left_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_align_i == 2'b01 && act_code_i != '0 && tick_i == '0) |-> pwm_o);

  p_right_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_align_i == 2'b10 && act_code_i != '0 && tick_i == ALL_ONES) |-> pwm_o);

  p_right_head_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_align_i == 2'b10 && act_code_i != ALL_ONES && tick_i == '0 && !force_hi_i) |-> !pwm_o);
endmodule

bind aligned_pwm aligned_pwm_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .force_hi_i  (force_hi_i),
  .pwm_o       (pwm_o),
  .tick_i      (tick_q),
  .act_code_i  (act_code),
  .act_align_i (act_align)
);

// File: tb/aligned_pwm_tb.sv
module aligned_pwm_tb;
  localparam int TICKS = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] code = '0;
  logic       single_edge = 1'b0;
  logic       late_edge = 1'b0;
  logic       force_hi = 1'b0;
  logic       pwm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit mon_on = 0;

  typedef struct {
    logic [TICKS-1:0] pat;
    string            tag;
  } item_t;

  item_t exp_q[$];

  always #4 clk = ~clk;

  aligned_pwm u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .code_i        (code),
    .single_edge_i (single_edge),
    .late_edge_i   (late_edge),
    .force_hi_i    (force_hi),
    .pwm_o         (pwm)
  );

  function automatic logic [TICKS-1:0] model(input logic [5:0] c, input logic s, input logic l);
    logic [TICKS-1:0] p = '0;
    int w  = (c == 0) ? 0 : int'(c) + 1;
    int st = !s ? (TICKS - w) / 2 : (l ? TICKS - w : 0);
    for (int t = 0; t < TICKS; t++) p[t] = (t >= st) && (t < st + w);
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [TICKS-1:0] act,
                       input logic [TICKS-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic s, input logic l, input string tag);
    item_t it;
    code = c; single_edge = s; late_edge = l;
    it.pat = model(c, s, l);
    it.tag = tag;
    exp_q.push_back(it);
    repeat (TICKS) @(posedge clk);
    #1;
  endtask

  // monitor: gather one period of samples, then compare with the oldest expectation
  logic [TICKS-1:0] got;
  int               slot = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      got[slot] = pwm;
      slot++;
      if (slot == TICKS) begin
        item_t e;
        slot = 0;
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected period", got, '0);
        else begin
          e = exp_q.pop_front();
          check(got === e.pat, e.tag, got, e.pat);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    item_t z;
    logic [TICKS-1:0] acc;
    repeat (3) @(posedge clk);
    #1;
    check(pwm === 1'b0, "R9 output during reset", {63'b0, pwm}, '0);
    z.pat = '0; z.tag = "R1 R9 first period after reset";
    exp_q.push_back(z);
    z.tag = "R1 R9 second period after reset";
    exp_q.push_back(z);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    mon_on = 1;

    drive(6'h3F, 1, 1, "R2 full right");
    drive(6'h3F, 0, 0, "R2 full centre");
    drive(6'h3F, 1, 0, "R2 full left");
    drive(6'h00, 1, 1, "R3 zero right");
    drive(6'h00, 0, 1, "R3 zero centre");
    drive(6'h1F, 1, 1, "R4 R5 half right");
    drive(6'h0F, 0, 1, "R4 R7 quarter centre late=1");
    drive(6'h0F, 0, 0, "R7 quarter centre late=0");
    drive(6'h2F, 1, 0, "R4 R6 three quarter left");
    drive(6'h02, 0, 0, "R7 odd spare centre");
    drive(6'h00, 1, 0, "R3 zero left");
    drive(6'h05, 1, 1, "R5 narrow right");
    drive(6'h20, 1, 0, "R6 wide left");
    drive(6'h00, 0, 0, "R3 zero tail");
    drive(6'h00, 0, 0, "R3 zero tail 2");
    wait (exp_q.size() == 0);
    #1 mon_on = 0;

    // R8: immediate effect between edges
    @(negedge clk); #1;
    force_hi = 1'b1;
    #1 check(pwm === 1'b1, "R8 force without edge", {63'b0, pwm}, 64'd1);
    force_hi = 1'b0;
    #1 check(pwm === 1'b0, "R8 force released", {63'b0, pwm}, '0);

    // R8: force held across a whole period of edges
    @(negedge clk); #1;
    force_hi = 1'b1;
    acc = '0;
    for (int t = 0; t < TICKS; t++) begin
      @(negedge clk);
      acc[t] = pwm;
    end
    check(acc === '1, "R8 force across edges", acc, '1);
    force_hi = 1'b0;

    // R9: async reset mid-period and restart latency
    code = 6'h3F; single_edge = 1'b1; late_edge = 1'b0;
    repeat (3 * TICKS) @(posedge clk);
    @(negedge clk); #1;
    check(pwm === 1'b1, "R2 full before reset", {63'b0, pwm}, 64'd1);
    rst_ni = 1'b0;
    #1 check(pwm === 1'b0, "R9 async reset low", {63'b0, pwm}, '0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    for (int p = 0; p < 3; p++) begin
      acc = '0;
      for (int t = 0; t < TICKS; t++) begin
        @(negedge clk);
        acc[t] = pwm;
      end
      if (p < 2) check(acc === '0, "R9 low periods after reset", acc, '0);
      else       check(acc === '1, "R1 R2 first captured period", acc, '1);
    end
    finish_run();
  end
endmodule